// File: doc/BRIEF.md
# Double-Width Sequential Divider with Range Fault

This block divides a dividend twice as wide as its data path, supplied as upper and lower halves, by a single-width divisor. It returns a single-width quotient and remainder. A mode input selects between unsigned arithmetic and two's complement arithmetic. The core is a restoring shift-subtract loop that resolves one quotient bit per clock. A signed operation first reduces both operands to magnitudes, runs the same unsigned loop, and then restores the signs and checks the result range.

A single fault flag covers every case where no valid quotient exists: a zero divisor, an unsigned quotient wider than the data path, and a signed quotient outside the asymmetric two's complement range. Cases that can be decided from the operands alone (a zero divisor, or an upper dividend half whose magnitude is not below the divisor magnitude) finish one cycle after start, without iterating. All other cases take the full iteration count.

Control runs through four named states. `S_IDLE` waits for start. `S_ITER` performs the W shift-subtract steps. `S_FIX` applies the sign correction and the range check. `S_DONE` presents the done pulse. The transitions are:
- `S_IDLE`→`S_ITER` on an accepted start with no early fault.
- `S_IDLE`→`S_DONE` on an accepted start with an early fault.
- `S_ITER`→`S_ITER` until the last step.
- `S_ITER`→`S_FIX` after step W.
- `S_FIX`→`S_DONE` always.
- `S_DONE`→`S_IDLE` when no start arrives.
- `S_DONE`→`S_ITER` or `S_DONE`→`S_DONE` when a new start is accepted in the done cycle.

Top module: `dbl_div`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) with a non-zero divisor and `dividend_hi` < `divisor`, `quotient` and `remainder` equal the floor quotient and remainder of the 2W-bit value {`dividend_hi`,`dividend_lo`} divided by `divisor`, and `fault` is 0.
- R2: A divisor of zero in either mode sets `fault`. `done` is then high in the cycle right after the clock edge that accepted start.
- R3: In unsigned mode, `dividend_hi` >= `divisor` sets `fault`, and `done` comes in the cycle right after the accepting edge, with no iteration.
- R4: In signed mode (`signed_mode`=1) the dividend is the 2W-bit two's complement {`dividend_hi`,`dividend_lo`} and the divisor is W-bit two's complement. When no fault occurs:
  - `quotient` is the quotient truncated toward zero.
  - `remainder` carries the sign of the dividend.
  - `remainder` has a magnitude below that of the divisor.
- R5: In signed mode, a fault is raised in each of these cases:
  - The operand signs differ and the quotient magnitude exceeds 2^(W-1).
  - The operand signs match and the quotient magnitude is 2^(W-1) or more.
  - The magnitude of the upper dividend half (after negating the whole dividend) is not below the divisor magnitude. In this case `done` comes one cycle after the accepting edge.
- R6: An operation without an early fault raises `done` in the cycle that follows W+1 clock edges after the accepting edge.
- R7: `done` is high for one cycle per operation. `busy` is high from the cycle after an iterating start until `done`. `busy` and `done` are never high together.
- R8: `quotient`, `remainder` and `fault` keep their values in every cycle where `done` is low.
- R9: A start raised while `busy` is high is ignored and does not alter the running operation's result.
- R10: A start raised in the `done` cycle is accepted, so operations can run back to back.
- R11: Whenever `fault` is 1, `quotient` and `remainder` read 0.
- R12: After reset, `busy`, `done`, `fault`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken in idle or done cycle) |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| dividend_hi | input | W | Upper half of the dividend |
| dividend_lo | input | W | Lower half of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | Iteration or fix-up in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient (0 on fault) |
| remainder | output | W | Remainder (0 on fault) |
| fault | output | 1 | Zero divisor or quotient out of range |

## Verification
The done pulse of one operation and the acceptance of the next start can fall in the same cycle. In that cycle the outputs of the finished operation must stay intact while fresh operands are captured. The bench provokes this on nearly every operation of its sweep by driving the next start at the very sample point where it sees `done`. It then judges both the latency and the result of the follow-on operation against an arithmetic model, including early faults that re-enter `S_DONE` directly.

// File: rtl/dbl_div_pkg.sv
package dbl_div_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ITER = 2'd1,
        S_FIX  = 2'd2,
        S_DONE = 2'd3
    } div_state_e;

endpackage

// File: rtl/dbl_div_prep.sv
// Operand conditioning: magnitudes, operand signs and early-fault detection.
module dbl_div_prep #(
    parameter int W = 16
) (
    input  logic         signed_mode,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] mag_hi,
    output logic [W-1:0] mag_lo,
    output logic [W-1:0] mag_div,
    output logic         neg_dividend,
    output logic         neg_divisor,
    output logic         early_fault
);
    localparam int DW = 2 * W;

    logic [DW-1:0] full_dividend;
    logic [DW-1:0] full_mag;

    always_comb begin
        neg_dividend  = signed_mode & dividend_hi[W-1];
        neg_divisor   = signed_mode & divisor[W-1];
        full_dividend = {dividend_hi, dividend_lo};
        full_mag      = neg_dividend ? (~full_dividend + DW'(1)) : full_dividend;
        mag_hi        = full_mag[DW-1:W];
        mag_lo        = full_mag[W-1:0];
        mag_div       = neg_divisor ? (~divisor + W'(1)) : divisor;
        // A zero divisor also satisfies this comparison.
        early_fault   = (mag_hi >= mag_div);
    end

endmodule

// File: rtl/dbl_div_step.sv
// One restoring shift-subtract step of the {hi, lo} accumulator.
module dbl_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic         out_bit;
    logic [W-1:0] shifted;
    logic         take;

    always_comb begin
        out_bit = acc_hi[W-1];
        shifted = {acc_hi[W-2:0], acc_lo[W-1]};
        take    = out_bit | (shifted >= dvs);
        nxt_hi  = take ? (shifted - dvs) : shifted;
        nxt_lo  = {acc_lo[W-2:0], take};
    end

endmodule

// File: rtl/dbl_div_fix.sv
// Sign restoration and signed range check after the unsigned loop.
module dbl_div_fix #(
    parameter int W = 16
) (
    input  logic         signed_mode,
    input  logic         neg_dividend,
    input  logic         neg_divisor,
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output logic         range_fault
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic signs_differ;

    always_comb begin
        signs_differ = neg_dividend ^ neg_divisor;
        if (!signed_mode) begin
            q_out       = q_mag;
            r_out       = r_mag;
            range_fault = 1'b0;
        end else begin
            range_fault = signs_differ ? (q_mag > HALF) : (q_mag >= HALF);
            q_out       = signs_differ ? (~q_mag + W'(1)) : q_mag;
            r_out       = neg_dividend ? (~r_mag + W'(1)) : r_mag;
        end
    end

endmodule

// File: rtl/dbl_div.sv
module dbl_div
    import dbl_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         fault
);
    localparam int          CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e   state, state_nxt;

    logic [W-1:0] acc_hi, acc_lo, div_r;
    logic         sm_r, nd_r, ns_r;
    logic [CW-1:0] cnt;
    logic [W-1:0] q_r, r_r;
    logic         f_r;

    logic [W-1:0] p_hi, p_lo, p_div;
    logic         p_nd, p_ns, p_early;
    logic [W-1:0] s_hi, s_lo;
    logic [W-1:0] f_q, f_r_val;
    logic         f_ovf;
    logic         accept;

    dbl_div_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .mag_hi      (p_hi),
        .mag_lo      (p_lo),
        .mag_div     (p_div),
        .neg_dividend(p_nd),
        .neg_divisor (p_ns),
        .early_fault (p_early)
    );

    dbl_div_step #(.W(W)) u_step (
        .acc_hi(acc_hi),
        .acc_lo(acc_lo),
        .dvs   (div_r),
        .nxt_hi(s_hi),
        .nxt_lo(s_lo)
    );

    dbl_div_fix #(.W(W)) u_fix (
        .signed_mode (sm_r),
        .neg_dividend(nd_r),
        .neg_divisor (ns_r),
        .q_mag       (acc_lo),
        .r_mag       (acc_hi),
        .q_out       (f_q),
        .r_out       (f_r_val),
        .range_fault (f_ovf)
    );

    assign accept = start && ((state == S_IDLE) || (state == S_DONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (accept) state_nxt = p_early ? S_DONE : S_ITER;
            S_ITER: if (cnt == LAST) state_nxt = S_FIX;
            S_FIX:  state_nxt = S_DONE;
            S_DONE: begin
                if (accept) state_nxt = p_early ? S_DONE : S_ITER;
                else        state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
            div_r  <= '0;
            sm_r   <= 1'b0;
            nd_r   <= 1'b0;
            ns_r   <= 1'b0;
            cnt    <= '0;
            q_r    <= '0;
            r_r    <= '0;
            f_r    <= 1'b0;
        end else if (accept) begin
            acc_hi <= p_hi;
            acc_lo <= p_lo;
            div_r  <= p_div;
            sm_r   <= signed_mode;
            nd_r   <= p_nd;
            ns_r   <= p_ns;
            cnt    <= '0;
            if (p_early) begin
                q_r <= '0;
                r_r <= '0;
                f_r <= 1'b1;
            end
        end else if (state == S_ITER) begin
            acc_hi <= s_hi;
            acc_lo <= s_lo;
            cnt    <= cnt + CW'(1);
        end else if (state == S_FIX) begin
            q_r <= f_ovf ? '0 : f_q;
            r_r <= f_ovf ? '0 : f_r_val;
            f_r <= f_ovf;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == S_ITER) || (state == S_FIX);
        done      = (state == S_DONE);
        quotient  = q_r;
        remainder = r_r;
        fault     = f_r;
    end

endmodule

// File: rtl/dbl_div_checker.sv
module dbl_div_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         fault
);

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    a_r2_zero_div_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (divisor == '0)) |=> (done && fault));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(fault)));

    a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ((quotient == '0) && (remainder == '0)));

    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind dbl_div dbl_div_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .quotient (quotient),
    .remainder(remainder),
    .fault    (fault)
);

// File: tb/dbl_div_bench.sv
`timescale 1ns/1ps
module dbl_div_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend_hi = '0;
    logic [W-1:0] dividend_lo = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, fault;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    dbl_div #(.W(W)) u_dbl_div (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .fault(fault)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Arithmetic model from the requirements
    task automatic model(input bit m, input logic [W-1:0] h, l, d,
                         output bit f, output logic [W-1:0] q, r, output bit early);
        longint unsigned un;
        longint n, dd, qq, rr, an, ad;
        logic signed [31:0] sn;
        f = 0; qq = 0; rr = 0;
        if (!m) begin
            un = {32'd0, h, l};
            early = (d == 0) || (h >= d);
            if (d == 0) f = 1;
            else begin
                qq = longint'(un / d);
                rr = longint'(un % d);
                if (qq > 65535) f = 1;
            end
        end else begin
            sn = {h, l};
            n  = sn;
            dd = longint'($signed(d));
            an = (n < 0) ? -n : n;
            ad = (dd < 0) ? -dd : dd;
            early = (d == 0) || ((an >> 16) >= ad);
            if (d == 0) f = 1;
            else begin
                qq = n / dd;
                rr = n % dd;
                if (qq < -32768 || qq > 32767) f = 1;
            end
        end
        q = f ? '0 : qq[15:0];
        r = f ? '0 : rr[15:0];
    endtask

    // Issue one operation; returns at the negedge where done is seen
    task automatic run_op(input bit m, input logic [W-1:0] h, l, d,
                          input bit inject, output int lat);
        signed_mode = m; dividend_hi = h; dividend_lo = l; divisor = d;
        start = 1'b1;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (inject && lat == 2 && busy) begin
                start = 1'b1; signed_mode = ~m; divisor = '0; dividend_hi = ~h;
            end
            if (inject && lat == 3) start = 1'b0;
            if (done) break;
            if (lat > 100) begin
                chk(0, "R7 done timeout", lat, W + 2);
                break;
            end
        end
    endtask

    task automatic do_case(input bit m, input logic [W-1:0] h, l, d,
                           input bit inject, input string tag);
        bit ef, ee;
        logic [W-1:0] eq, er;
        int lat;
        string t;
        model(m, h, l, d, ef, eq, er, ee);
        run_op(m, h, l, d, inject, lat);
        if (tag != "") t = tag;
        else if (d == 0) t = "R2";
        else if (ef) t = m ? "R5" : "R3";
        else t = m ? "R4" : "R1";
        chk(fault == ef, {t, " fault"}, fault, ef);
        chk(quotient == eq, {t, ef ? " R11 quotient" : " quotient"}, quotient, eq);
        chk(remainder == er, {t, ef ? " R11 remainder" : " remainder"}, remainder, er);
        if (ee) chk(lat == 1, {t, " early latency"}, lat, 1);
        else    chk(lat == W + 2, "R6 latency", lat, W + 2);
    endtask

    initial begin
        #3_800_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] sq, sr;
        logic         sf;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(busy == 0 && done == 0, "R12 ctrl", {busy, done}, 0);
        chk(fault == 0 && quotient == 0 && remainder == 0, "R12 data",
            {fault, quotient, remainder}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        do_case(0, 16'h0000, 16'd1000, 16'd7, 0, "R1");
        do_case(0, 16'h1234, 16'h5678, 16'h0000, 0, "R2");
        do_case(1, 16'hFFFF, 16'hFFF0, 16'h0000, 0, "R2");
        do_case(0, 16'h0007, 16'h0000, 16'h0007, 0, "R3");
        do_case(0, 16'h0006, 16'hFFFF, 16'h0007, 0, "R1");
        do_case(1, 16'hFFFF, 16'hFFF9, 16'h0002, 0, "R4");
        do_case(1, 16'h0000, 16'h0007, 16'hFFFE, 0, "R4");
        do_case(1, 16'hFFFF, 16'h8000, 16'h0001, 0, "R5");
        do_case(1, 16'h0000, 16'h8000, 16'h0001, 0, "R5");
        do_case(1, 16'hFFFF, 16'h8000, 16'hFFFF, 0, "R5");
        do_case(1, 16'h0000, 16'h8000, 16'hFFFF, 0, "R5");
        do_case(1, 16'h8000, 16'h0000, 16'hFFFF, 0, "R5");
        do_case(1, 16'hC000, 16'h0000, 16'h8000, 0, "R5");
        do_case(1, 16'h3FFF, 16'h8000, 16'h8000, 0, "R5");

        // R9: start while busy is ignored
        do_case(0, 16'h0123, 16'h4567, 16'h0F0F, 1, "R9");
        do_case(1, 16'hFFFE, 16'h1357, 16'h7531, 1, "R9");

        // R7/R8: single done pulse and hold
        sq = quotient; sr = remainder; sf = fault;
        @(negedge clk);
        chk(done == 0, "R7 single pulse", done, 0);
        repeat (5) @(negedge clk);
        chk(quotient == sq && remainder == sr && fault == sf, "R8 hold",
            {fault, quotient, remainder}, {sf, sq, sr});

        // R10: back-to-back, second start in the done cycle
        do_case(0, 16'h0001, 16'h0000, 16'h0003, 0, "R1");
        do_case(1, 16'h0000, 16'h0064, 16'hFFF9, 0, "R10");
        do_case(0, 16'h0009, 16'h0000, 16'h0002, 0, "R10");
        do_case(0, 16'h0000, 16'hFFFF, 16'h0010, 0, "R10");

        // Sweep with arithmetic expectation
        for (int i = 0; i < 3200; i++) begin
            logic [31:0] a, b, c;
            logic [W-1:0] h, l, d;
            bit m;
            a = nxt(); b = nxt(); c = nxt();
            m = a[0];
            d = b[15:0] >> (a[5:2]);
            l = c[15:0];
            unique case (a[7:6])
                2'd0: h = c[31:16];
                2'd1: h = (d == 0) ? 16'h0000 : (c[31:16] % d);
                2'd2: h = {16{l[15]}} ^ (c[31:16] >> (4 + a[11:8]));
                default: h = {16{l[15]}};
            endcase
            if (a[12] && m) d = -d;
            do_case(m, h, l, d, 0, "");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule